// File: doc/BRIEF.md
# PCI Type 0 Configuration Header Register File

This block is the 64-byte Type 0 configuration header of a PCI target, built as a register file. A configuration-cycle controller presents a dword index (0 to 15), four byte enables, a read strobe, a write strobe and write data. Writes take effect at the next clock edge. Read data is returned combinationally in the same cycle as the read strobe.

The header holds the identification fields, which are fixed by parameters. It also holds the Command and Status registers, Cache Line Size, Latency Timer, Interrupt Line and Interrupt Pin, and up to three Base Address Registers (BARs). Each BAR is enabled, typed as memory or I/O, and sized by parameter. Address bits below the BAR's size are hardwired to zero, so software can find the size by writing all ones. The rest of the target receives the live Command bits and the decoded BAR bases. It reports bus events into the sticky Status bits, which software clears by writing ones. Every location that is not implemented reads as zero.

Top module: `cfg_hdr_space`

## Requirements
- R1: After reset, Command, the six sticky Status bits, Cache Line Size, Latency Timer, Interrupt Line and every implemented BAR address field read zero.
- R2: Index 0 reads {DEVICE_ID, VENDOR_ID} and index 2 reads {CLASS_CODE, REV_ID}. Writes to either index leave them unchanged.
- R3: Read data is valid in the same cycle as `cfg_rd_i` and is all zero while `cfg_rd_i` is low.
- R4: Command is the low half of index 1. Only Command bits 0, 1, 2, 6, 8 and 10 are writable, the other Command bits read zero, and each Command byte changes only when its byte enable is set.
- R5: Status is the high half of index 1. Status bits 8 and 11 to 15 are cleared by writing 1 to them with byte enable 3 set. A clear and a set on the same bit in the same cycle leave the bit set. Status bits 10:9 read 01, bit 5 reads CAP_66, and all other Status bits read zero.
- R6: A BAR's bits below its SIZE_LOG2 read zero. After all ones are written, a memory BAR reads the size mask with bits 3:0 zero, and an I/O BAR reads the size mask with bit 0 set.
- R7: A BAR at index 4+n changes only in the bytes whose enables are set. `bar_base_o[32n+31:32n]` carries the BAR value without the type bit.
- R8: Indices 7 to 14, and any BAR whose BAR_EN bit is clear, read zero and ignore writes. The base output of a disabled BAR is zero.
- R9: Index 3 has Cache Line Size in byte 0 and Latency Timer in byte 1. Both are byte-qualified read-write, and the upper two bytes read zero. Index 15 has a read-write Interrupt Line in byte 0 and a read-only INT_PIN in byte 1, with bytes 2 and 3 reading zero.
- R10: A high `evt_i` bit sets a Status bit at the next edge. The mapping is: bit 0 sets Status bit 8, bit 1 sets bit 11, bit 2 sets bit 12, bit 3 sets bit 13, bit 4 sets bit 14, and bit 5 sets bit 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_idx_i | input | 4 | Dword index into the header |
| cfg_be_i | input | 4 | Byte enables for writes |
| cfg_wr_i | input | 1 | Write strobe |
| cfg_rd_i | input | 1 | Read strobe |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Read data, same cycle |
| evt_i | input | 6 | Status event pulses from the target |
| cmd_o | output | 16 | Current Command register |
| bar_base_o | output | 96 | Decoded bases of BAR0..BAR2 |

## Verification
The bench builds the block with these BARs:
- BAR0 is a memory BAR sized 2 GB (SIZE_LOG2 31), so an all-ones probe leaves only bit 31 set.
- BAR1 is an I/O BAR at the 16-byte minimum (SIZE_LOG2 4), so an all-ones probe reads the widest mask together with the I/O type bit.
- BAR2 is disabled, which exposes the read-as-zero and write-ignore behaviour of an unimplemented BAR.

CAP_66 is set and the identification parameters are distinct, so each field's position in its dword can be seen.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;
  localparam int unsigned DW        = 32;
  localparam int unsigned IDX_W     = 4;
  localparam int unsigned NBAR      = 3;
  localparam int unsigned LOG2_W    = 5;
  localparam int unsigned NSTAT     = 6;
  localparam logic [15:0] CMD_WMASK = 16'h0547;
  localparam logic [1:0]  DEVSEL_MED = 2'b01;

  typedef enum logic [IDX_W-1:0] {
    IDX_ID   = 4'd0,
    IDX_CS   = 4'd1,
    IDX_CLS  = 4'd2,
    IDX_MISC = 4'd3,
    IDX_BAR0 = 4'd4,
    IDX_INT  = 4'd15
  } cfg_idx_e;
endpackage

// File: rtl/cfg_hdr_status.sv
module cfg_hdr_status
  import cfg_hdr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NSTAT-1:0] evt_i,
  input  logic [NSTAT-1:0] clr_i,
  output logic [NSTAT-1:0] flags_o
);
  logic [NSTAT-1:0] flags_q;

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (flags_q & ~clr_i) | evt_i;
  end

  assign flags_o = flags_q;

  for (genvar i = 0; i < NSTAT; i++) begin : g_ast
    AST_EVT_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[i] |=> flags_o[i]); // R10
    AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[i] && !evt_i[i]) |=> !flags_o[i]); // R5
  end
endmodule

// File: rtl/cfg_hdr_bar.sv
module cfg_hdr_bar
  import cfg_hdr_pkg::*;
#(
  parameter bit          IS_IO     = 1'b0,
  parameter int unsigned SIZE_LOG2 = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [3:0]    be_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] base_o
);
  localparam logic [DW-1:0] AMASK = ~((DW'(1) << SIZE_LOG2) - DW'(1));
  localparam logic [DW-1:0] TYPE  = IS_IO ? DW'(1) : DW'(0);

  logic [DW-1:0] bar_q, bmask;

  initial begin
    if (SIZE_LOG2 < 4 || SIZE_LOG2 > 31) $error("BAR size out of range");
  end

  always_comb begin
    for (int b = 0; b < 4; b++) bmask[b*8 +: 8] = {8{be_i[b]}};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   bar_q <= '0;
    else if (we_i) bar_q <= ((bar_q & ~bmask) | (wdata_i & bmask)) & AMASK;
  end

  assign base_o  = bar_q;
  assign rdata_o = bar_q | TYPE;

  AST_BAR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(base_o)); // R7
endmodule

// File: rtl/cfg_hdr_space.sv
module cfg_hdr_space
  import cfg_hdr_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID  = 16'h10EE,
  parameter logic [15:0] DEVICE_ID  = 16'h0300,
  parameter logic [7:0]  REV_ID     = 8'h00,
  parameter logic [23:0] CLASS_CODE = 24'h058000,
  parameter logic [7:0]  INT_PIN    = 8'h01,
  parameter bit          CAP_66     = 1'b0,
  parameter logic [2:0]  BAR_EN     = 3'b111,
  parameter logic [2:0]  BAR_IO     = 3'b000,
  parameter logic [14:0] BAR_LOG2   = {5'd12, 5'd12, 5'd12}
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [3:0]  cfg_idx_i,
  input  logic [3:0]  cfg_be_i,
  input  logic        cfg_wr_i,
  input  logic        cfg_rd_i,
  input  logic [31:0] cfg_wdata_i,
  output logic [31:0] cfg_rdata_o,
  input  logic [5:0]  evt_i,
  output logic [15:0] cmd_o,
  output logic [95:0] bar_base_o
);
  logic [15:0]      cmd_q;
  logic [7:0]       cls_q, lat_q, iline_q;
  logic [NSTAT-1:0] st_flags, st_clr;
  logic [15:0]      status;
  logic [DW-1:0]    bar_rd [NBAR];
  logic             we_cs, we_misc, we_int;

  assign we_cs   = cfg_wr_i && (cfg_idx_i == IDX_CS);
  assign we_misc = cfg_wr_i && (cfg_idx_i == IDX_MISC);
  assign we_int  = cfg_wr_i && (cfg_idx_i == IDX_INT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q   <= '0;
      cls_q   <= '0;
      lat_q   <= '0;
      iline_q <= '0;
    end else begin
      if (we_cs && cfg_be_i[0])   cmd_q[7:0]  <= cfg_wdata_i[7:0]   & CMD_WMASK[7:0];
      if (we_cs && cfg_be_i[1])   cmd_q[15:8] <= cfg_wdata_i[15:8]  & CMD_WMASK[15:8];
      if (we_misc && cfg_be_i[0]) cls_q       <= cfg_wdata_i[7:0];
      if (we_misc && cfg_be_i[1]) lat_q       <= cfg_wdata_i[15:8];
      if (we_int && cfg_be_i[0])  iline_q     <= cfg_wdata_i[7:0];
    end
  end

  assign cmd_o = cmd_q;

  // sticky status bits live in byte 3 of the Command/Status dword
  assign st_clr = {NSTAT{we_cs && cfg_be_i[3]}} &
                  {cfg_wdata_i[31], cfg_wdata_i[30], cfg_wdata_i[29],
                   cfg_wdata_i[28], cfg_wdata_i[27], cfg_wdata_i[24]};

  cfg_hdr_status u_status (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (evt_i),
    .clr_i   (st_clr),
    .flags_o (st_flags)
  );

  assign status = {st_flags[5:1], DEVSEL_MED, st_flags[0], 2'b00, CAP_66, 5'b00000};

  for (genvar g = 0; g < NBAR; g++) begin : g_bar
    if (BAR_EN[g]) begin : g_on
      logic we_bar;
      assign we_bar = cfg_wr_i && (cfg_idx_i == IDX_BAR0 + IDX_W'(g));
      cfg_hdr_bar #(
        .IS_IO     (BAR_IO[g]),
        .SIZE_LOG2 (int'(BAR_LOG2[g*LOG2_W +: LOG2_W]))
      ) u_bar (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (we_bar),
        .be_i    (cfg_be_i),
        .wdata_i (cfg_wdata_i),
        .rdata_o (bar_rd[g]),
        .base_o  (bar_base_o[g*DW +: DW])
      );
    end else begin : g_off
      assign bar_rd[g]             = '0;
      assign bar_base_o[g*DW +: DW] = '0;
    end
  end

  always_comb begin
    cfg_rdata_o = '0;
    if (cfg_rd_i) begin
      case (cfg_idx_i)
        4'd0:    cfg_rdata_o = {DEVICE_ID, VENDOR_ID};
        4'd1:    cfg_rdata_o = {status, cmd_q};
        4'd2:    cfg_rdata_o = {CLASS_CODE, REV_ID};
        4'd3:    cfg_rdata_o = {16'h0000, lat_q, cls_q};
        4'd4:    cfg_rdata_o = bar_rd[0];
        4'd5:    cfg_rdata_o = bar_rd[1];
        4'd6:    cfg_rdata_o = bar_rd[2];
        4'd15:   cfg_rdata_o = {16'h0000, INT_PIN, iline_q};
        default: cfg_rdata_o = '0;
      endcase
    end
  end

  AST_CMD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_cs |=> $stable(cmd_o)); // R4
  AST_LT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_misc && cfg_be_i[1]) |=> $stable(lat_q)); // R9
  AST_CMD_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_cs |=> ((cmd_o & ~CMD_WMASK) == 16'h0)); // R4
endmodule

// File: tb/cfg_hdr_space_tb_top.sv
`timescale 1ns/1ps
module cfg_hdr_space_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  idx = '0, be = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0, rdata;
  logic [5:0]  evt = '0;
  logic [15:0] cmd;
  logic [95:0] bases;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cfg_hdr_space #(
    .VENDOR_ID (16'h1D0F), .DEVICE_ID (16'hB0A7), .REV_ID (8'h03),
    .CLASS_CODE(24'h0B4000), .INT_PIN (8'h01), .CAP_66 (1'b1),
    .BAR_EN (3'b011), .BAR_IO (3'b010),
    .BAR_LOG2 ({5'd12, 5'd4, 5'd31})
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_idx_i(idx), .cfg_be_i(be),
    .cfg_wr_i(wr), .cfg_rd_i(rd), .cfg_wdata_i(wdata), .cfg_rdata_o(rdata),
    .evt_i(evt), .cmd_o(cmd), .bar_base_o(bases)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic cfg_wr(input logic [3:0] i, input logic [3:0] b, input logic [31:0] d);
    @(negedge clk);
    idx = i; be = b; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; be = '0;
  endtask

  task automatic cfg_rd(input logic [3:0] i, output logic [31:0] d);
    @(negedge clk);
    idx = i; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] i, input logic [31:0] exp);
    logic [31:0] d;
    cfg_rd(i, d);
    check(req, d, exp);
  endtask

  task automatic t_reset;
    rd_chk("R1 cmd/status", 4'd1, 32'h0220_0000);
    rd_chk("R1 cls/lat", 4'd3, 32'h0);
    rd_chk("R1 bar0", 4'd4, 32'h0);
    rd_chk("R1 bar1", 4'd5, 32'h1);
    rd_chk("R1 int", 4'd15, 32'h0000_0100);
    check("R1 cmd_o", {16'h0, cmd}, 32'h0);
  endtask

  task automatic t_ident;
    cfg_wr(4'd0, 4'hF, 32'h0);
    cfg_wr(4'd2, 4'hF, 32'h0);
    rd_chk("R2 id", 4'd0, 32'hB0A7_1D0F);
    rd_chk("R2 class/rev", 4'd2, 32'h0B40_0003);
  endtask

  task automatic t_rd_idle;
    @(negedge clk);
    idx = 4'd0; rd = 1'b0;
    #1 check("R3 idle read zero", rdata, 32'h0);
  endtask

  task automatic t_cmd;
    cfg_wr(4'd1, 4'b0011, 32'h0000_FFFF);
    rd_chk("R4 cmd mask", 4'd1, 32'h0220_0547);
    check("R4 cmd_o", {16'h0, cmd}, 32'h0000_0547);
    cfg_wr(4'd1, 4'b0001, 32'h0000_0000);
    rd_chk("R4 cmd byte enable", 4'd1, 32'h0220_0500);
  endtask

  task automatic t_status;
    @(negedge clk); evt = 6'h3F;
    @(negedge clk); evt = 6'h00;
    rd_chk("R10 all events", 4'd1, 32'hFB20_0500);
    cfg_wr(4'd1, 4'b0111, 32'hFFFF_0500);
    rd_chk("R5 no clear without be3", 4'd1, 32'hFB20_0500);
    cfg_wr(4'd1, 4'b1000, 32'h8000_0000);
    rd_chk("R5 w1c bit15", 4'd1, 32'h7B20_0500);
    @(negedge clk);
    idx = 4'd1; be = 4'b1000; wdata = 32'h0100_0000; wr = 1'b1; evt = 6'h01;
    @(negedge clk);
    wr = 1'b0; be = '0; evt = '0;
    rd_chk("R5 set wins over clear", 4'd1, 32'h7B20_0500);
    cfg_wr(4'd1, 4'b1000, 32'hFF00_0000);
    rd_chk("R5 clear all", 4'd1, 32'h0220_0500);
    @(negedge clk); evt = 6'h04;
    @(negedge clk); evt = 6'h00;
    rd_chk("R10 evt2 -> bit12", 4'd1, 32'h1220_0500);
  endtask

  task automatic t_bar;
    cfg_wr(4'd4, 4'hF, 32'hFFFF_FFFF);
    rd_chk("R6 mem bar 2GB", 4'd4, 32'h8000_0000);
    check("R7 base0", bases[31:0], 32'h8000_0000);
    cfg_wr(4'd5, 4'hF, 32'hFFFF_FFFF);
    rd_chk("R6 io bar 16B", 4'd5, 32'hFFFF_FFF1);
    check("R7 base1", bases[63:32], 32'hFFFF_FFF0);
    cfg_wr(4'd5, 4'b0010, 32'h0);
    rd_chk("R7 bar byte enable", 4'd5, 32'hFFFF_00F1);
    cfg_wr(4'd4, 4'b0111, 32'h0);
    rd_chk("R7 bar byte enable keep", 4'd4, 32'h8000_0000);
  endtask

  task automatic t_unimpl;
    cfg_wr(4'd6, 4'hF, 32'hFFFF_FFFF);
    rd_chk("R8 disabled bar", 4'd6, 32'h0);
    check("R8 disabled base", bases[95:64], 32'h0);
    for (int i = 7; i < 15; i++) begin
      cfg_wr(4'(i), 4'hF, 32'hFFFF_FFFF);
      rd_chk("R8 unimplemented idx", 4'(i), 32'h0);
    end
  endtask

  task automatic t_misc;
    cfg_wr(4'd3, 4'hF, 32'hFFFF_FFFF);
    rd_chk("R9 cls/lat all ones", 4'd3, 32'h0000_FFFF);
    cfg_wr(4'd3, 4'b0001, 32'h0000_0010);
    rd_chk("R9 cls byte", 4'd3, 32'h0000_FF10);
    cfg_wr(4'd15, 4'hF, 32'hFFFF_FFFF);
    rd_chk("R9 int line/pin", 4'd15, 32'h0000_01FF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_ident;
    t_rd_idle;
    t_cmd;
    t_status;
    t_bar;
    t_unimpl;
    t_misc;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule